// File: doc/BRIEF.md
# Power-Down Freeze and Input Hold Unit

This unit sits between the device pins and a programmable logic core. A single control pin can put the core into a frozen low-power state. While frozen, the core's register clock enable is held off. The logic array inputs keep the values they had just before the freeze. The pad outputs keep the values the core presented at the moment the freeze took effect. Pin changes and core output changes are both ignored until the unit wakes.

A configuration bit chooses the role of the control pin. With the bit set, the pin is the freeze request, and the array sees a constant low in that pin's slot. With the bit clear, the pin is an ordinary logic input and no freeze can occur.

Every input, the control pin included, passes through a keeper. A per-pin drive-valid signal marks whether the pin is being driven. An undriven pin presents its last driven level. The keepers stay active while the core is frozen.

After the request is released, inputs and the clock enable return at once. A readiness flag stays low for a parameterised number of cycles and then rises.

Top module: `freeze_ctrl`

## Requirements
- R1: After reset the unit is running: `core_ce` = 1, `wake_ready` = 1, and with no pin driven every bit of `arr_in` and `arr_pd` reads 0.
- R2: With `cfg_pd_en` = 0, the control pin level (after its keeper) appears on `arr_pd`, and `core_ce` stays 1 whatever the pin does.
- R3: With `cfg_pd_en` = 1, `arr_pd` is 0 regardless of the control pin.
- R4: With `cfg_pd_en` = 1, the control level high at a rising clock edge makes `core_ce` 0 from that edge on. `core_ce` remains 0 for as long as the level stays high.
- R5: While frozen, `arr_in` holds the value it had in the cycle before the freezing edge, whatever `pin_in` and `pin_drv` do.
- R6: While frozen, `pad_out` holds the value `core_out` had in the cycle before the freezing edge, whatever `core_out` does. This includes bits whose value was undetermined.
- R7: Bit i of `arr_in` follows `pin_in[i]` in the same cycle while `pin_drv[i]` = 1. While `pin_drv[i]` = 0 it holds the level last driven at a clock edge.
- R8: The keepers keep tracking driven pins while frozen. A value driven and then released during the freeze appears on `arr_in` once the unit wakes.
- R9: The control level low at a rising edge while frozen restores `core_ce` = 1 from that edge. From that edge `arr_in` follows the kept pins and `pad_out` equals `core_out` again.
- R10: `wake_ready` is 0 while frozen. It rises exactly WAKE_CYC rising edges after the edge that ended the freeze; the default is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pd_en | input | 1 | 1: control pin requests freeze; 0: control pin is a plain input |
| pd_pin | input | 1 | Control pin level |
| pd_drv | input | 1 | Control pin is driven |
| pin_in | input | N_IN | Logic input pin levels |
| pin_drv | input | N_IN | Per-pin drive-valid |
| arr_in | output | N_IN | Inputs presented to the logic array |
| arr_pd | output | 1 | Control pin slot of the logic array |
| core_ce | output | 1 | Register clock enable for the core |
| core_out | input | N_OUT | Outputs produced by the core |
| pad_out | output | N_OUT | Outputs presented to the pads |
| wake_ready | output | 1 | Outputs valid after recovery |

## Verification
The freeze is entered with known pin and core values. Both pins and core outputs are then changed to their bit inverses, so a held value can be told apart from a live one on every bit. The keepers are tried with a partial drive mask, which separates bits that track the pin from bits that hold. They are also driven and released in the middle of a freeze, which shows that the keepers keep running while the array inputs are blocked. The readiness flag is sampled one cycle before and exactly at the end of the recovery count, which exposes an off-by-one in the counter. The plain-input mode toggles the control pin and confirms that the enable never drops.

// File: rtl/freeze_pkg.sv
// Shared types and helpers for the power-down freeze unit.
// Assumes: nothing beyond standard SystemVerilog.
package freeze_pkg;

    // Operating phase of the freeze sequencer.
    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_SLEEP   = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // Width needed to count down from n-1 to 0, at least one bit.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pin_keeper.sv
// Per-pin hold latch modelling a weak bus keeper.
// A driven pin passes straight through; an undriven pin shows the level
// captured at the last clock edge. Assumes: drive-valid is synchronous.
module pin_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] kept
);

    logic [W-1:0] last_q;

    // One transparent-when-driven cell per pin.
    generate
        for (genvar i = 0; i < W; i++) begin : g_cell
            assign kept[i] = drv[i] ? pin[i] : last_q[i];
        end
    endgenerate

    // Remember the presented level for the next undriven cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= kept;
    end

endmodule

// File: rtl/freeze_stage.sv
// Freezable pass-through: while `freeze` is low the output follows `d`
// and a shadow copy is taken each edge; while high the shadow is shown.
// Assumes: `freeze` is a registered signal changing only at clock edges.
module freeze_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] shadow_q;

    // Capture the live value every running cycle, keep it while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (!freeze) shadow_q <= d;
    end

    // Select live or shadowed data.
    always_comb begin
        q = freeze ? shadow_q : d;
    end

endmodule

// File: rtl/pd_sequencer.sv
// Freeze sequencer: enters sleep on a sampled request, leaves it on the
// sampled release, then counts WAKE_CYC edges before flagging readiness.
// Assumes: WAKE_CYC >= 1.
module pd_sequencer
    import freeze_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic ctl_level,
    output logic asleep,
    output logic ready
);

    localparam int CW = cnt_width(WAKE_CYC);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WAKE_CYC - 1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          req;

    // Freeze is requested only when the pin has that role.
    assign req = cfg_en & ctl_level;

    // Next phase and recovery count.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_RUN: begin
                if (req) phase_d = PH_SLEEP;
            end
            PH_SLEEP: begin
                if (!req) begin
                    phase_d = PH_RECOVER;
                    cnt_d   = CNT_LOAD;
                end
            end
            PH_RECOVER: begin
                if (req)              phase_d = PH_SLEEP;
                else if (cnt_q == '0) phase_d = PH_RUN;
                else                  cnt_d   = cnt_q - 1'b1;
            end
            default: phase_d = PH_RUN;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign asleep = (phase_q == PH_SLEEP);
    assign ready  = (phase_q == PH_RUN);

endmodule

// File: rtl/freeze_ctrl.sv
// Top of the power-down freeze unit. Keepers condition all pins, the
// sequencer decides the phase, and two freeze stages hold array inputs
// and pad outputs. Assumes: one clock domain, synchronous active-low reset.
module freeze_ctrl #(
    parameter int N_IN     = 8,
    parameter int N_OUT    = 6,
    parameter int WAKE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pd_en,
    input  logic             pd_pin,
    input  logic             pd_drv,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_IN-1:0]  pin_drv,
    output logic [N_IN-1:0]  arr_in,
    output logic             arr_pd,
    output logic             core_ce,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pad_out,
    output logic             wake_ready
);

    localparam int NK = N_IN + 1;

    logic [NK-1:0] kept;
    logic          asleep;

    // Keepers on every pin; the control pin is the top slot.
    pin_keeper #(.W(NK)) u_keep (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({pd_pin, pin_in}),
        .drv  ({pd_drv, pin_drv}),
        .kept (kept)
    );

    pd_sequencer #(.WAKE_CYC(WAKE_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_pd_en),
        .ctl_level(kept[N_IN]),
        .asleep   (asleep),
        .ready    (wake_ready)
    );

    // Block the array inputs while asleep.
    freeze_stage #(.W(N_IN)) u_in_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .freeze(asleep),
        .d     (kept[N_IN-1:0]),
        .q     (arr_in)
    );

    // Hold the pad outputs while asleep.
    freeze_stage #(.W(N_OUT)) u_out_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .freeze(asleep),
        .d     (core_out),
        .q     (pad_out)
    );

    // Control pin slot of the array: constant when it serves as freeze request.
    always_comb begin
        arr_pd = cfg_pd_en ? 1'b0 : kept[N_IN];
    end

    assign core_ce = ~asleep;

endmodule

// File: rtl/freeze_ctrl_chk.sv
// Property checker for freeze_ctrl, attached by bind.
// Assumes: ports observed exactly as seen at the top module boundary.
module freeze_ctrl_chk #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_pd_en,
    input logic             pd_pin,
    input logic             pd_drv,
    input logic [N_IN-1:0]  arr_in,
    input logic             arr_pd,
    input logic             core_ce,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] pad_out,
    input logic             wake_ready
);

    // R3: the control slot reads low whenever it is the freeze request.
    a_r3_pd_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pd_en |-> (arr_pd == 1'b0));

    // R2: plain-input mode never drops the enable.
    a_r2_plain_runs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cfg_pd_en && $past(!cfg_pd_en) && $past(!core_ce) == 1'b0) |-> core_ce);

    // R4: a driven-high request sampled in enabled mode freezes the core.
    a_r4_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_pd_en && pd_drv && pd_pin)) |-> !core_ce);

    // R5: array inputs do not move between two frozen cycles.
    a_r5_inputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !core_ce && $past(!core_ce)) |-> $stable(arr_in));

    // R6: pad outputs do not move between two frozen cycles.
    a_r6_pads_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !core_ce && $past(!core_ce)) |-> $stable(pad_out));

    // R9: while running, pads show the core outputs.
    a_r9_pads_live: assert property (@(posedge clk) disable iff (!rst_n)
        core_ce |-> (pad_out === core_out));

    // R10: readiness is never flagged while frozen.
    a_r10_not_ready_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ce |-> !wake_ready);

endmodule

bind freeze_ctrl freeze_ctrl_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pd_en (cfg_pd_en),
    .pd_pin    (pd_pin),
    .pd_drv    (pd_drv),
    .arr_in    (arr_in),
    .arr_pd    (arr_pd),
    .core_ce   (core_ce),
    .core_out  (core_out),
    .pad_out   (pad_out),
    .wake_ready(wake_ready)
);

// File: tb/freeze_ctrl_test.sv
`timescale 1ns/1ps
module freeze_ctrl_test;

    localparam int N_IN     = 8;
    localparam int N_OUT    = 6;
    localparam int WAKE_CYC = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_pd_en;
    logic             pd_pin;
    logic             pd_drv;
    logic [N_IN-1:0]  pin_in;
    logic [N_IN-1:0]  pin_drv;
    logic [N_IN-1:0]  arr_in;
    logic             arr_pd;
    logic             core_ce;
    logic [N_OUT-1:0] core_out;
    logic [N_OUT-1:0] pad_out;
    logic             wake_ready;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    freeze_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .WAKE_CYC(WAKE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
        .pd_drv(pd_drv), .pin_in(pin_in), .pin_drv(pin_drv), .arr_in(arr_in),
        .arr_pd(arr_pd), .core_ce(core_ce), .core_out(core_out),
        .pad_out(pad_out), .wake_ready(wake_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge.
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cfg_pd_en = 1'b1; pd_pin = 1'b0; pd_drv = 1'b0;
        pin_in = '0; pin_drv = '0; core_out = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 core_ce", core_ce, 1);
        check("R1 wake_ready", wake_ready, 1);
        check("R1 arr_in", arr_in, 0);
        check("R1 arr_pd", arr_pd, 0);
    endtask

    task automatic t_plain_mode;
        cfg_pd_en = 1'b0; pd_drv = 1'b1; pd_pin = 1'b1;
        step(1);
        check("R2 arr_pd high", arr_pd, 1);
        step(2);
        check("R2 core_ce stays", core_ce, 1);
        pd_pin = 1'b0;
        step(1);
        check("R2 arr_pd low", arr_pd, 0);
        check("R2 core_ce", core_ce, 1);
    endtask

    task automatic t_keeper;
        pin_drv = '1; pin_in = 8'hA5;
        #1;
        check("R7 follow same cycle", arr_in, 8'hA5);
        step(1);
        pin_drv = 8'h0F; pin_in = 8'h00;
        #1;
        check("R7 partial drive", arr_in, 8'hA0);
        step(1);
        pin_drv = '0; pin_in = 8'hFF;
        step(2);
        check("R7 hold undriven", arr_in, 8'hA0);
    endtask

    task automatic t_sleep_hold;
        cfg_pd_en = 1'b1; pd_drv = 1'b1; pd_pin = 1'b0;
        pin_drv = '1; pin_in = 8'h3C; core_out = 6'h15;
        step(1);
        check("R3 arr_pd masked", arr_pd, 0);
        pd_pin = 1'b1;
        step(1);
        check("R4 core_ce off", core_ce, 0);
        check("R3 arr_pd masked asleep", arr_pd, 0);
        check("R10 not ready asleep", wake_ready, 0);
        pin_in = 8'hC3; core_out = 6'h2A;
        step(2);
        check("R4 core_ce stays off", core_ce, 0);
        check("R5 arr_in held", arr_in, 8'h3C);
        check("R6 pad_out held", pad_out, 6'h15);
    endtask

    task automatic t_keeper_in_sleep;
        pin_in = 8'h5A; pin_drv = '1;
        step(1);
        pin_drv = '0; pin_in = 8'h00;
        step(1);
        check("R5 blocked during keeper change", arr_in, 8'h3C);
    endtask

    task automatic t_wake;
        core_out = 6'h33;
        pd_pin = 1'b0;
        step(1);
        check("R9 core_ce back", core_ce, 1);
        check("R8 kept value after wake", arr_in, 8'h5A);
        check("R9 pad_out live", pad_out, 6'h33);
        check("R10 not ready yet", wake_ready, 0);
        step(WAKE_CYC - 1);
        check("R10 one short", wake_ready, 0);
        step(1);
        check("R10 ready at count", wake_ready, 1);
    endtask

    task automatic t_undetermined;
        core_out = 6'b1x0x10;
        pd_pin = 1'b1;
        step(1);
        core_out = 6'b010101;
        step(1);
        check("R6 undetermined held", pad_out, 32'(6'b1x0x10));
        pd_pin = 1'b0;
        step(WAKE_CYC + 1);
        check("R10 ready again", wake_ready, 1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain_mode();
        t_keeper();
        t_sleep_hold();
        t_keeper_in_sleep();
        t_wake();
        t_undetermined();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule